// File: doc/BRIEF.md
# Flash Program Word Assembler

This block sits between the processor data bus and a flash array. While programming is enabled, processor writes that land in the flash address window (top address byte 0x08) are collected into one program unit. A unit is 32 bits or 64 bits, depending on a width-select control bit. The block accepts halfword or word beats. Once a unit is complete, the block checks the target page against a write-protect mask and checks that the target location still reads as erased. It then issues exactly one program operation to the array and waits for the array to report completion.

Software reaches the block through a two-entry register port. Entry 0 is control and entry 1 is status. Control holds the program enable, the width select, the two interrupt enables and a lock bit. Status holds a busy flag and three sticky event flags: end of operation, program error and alignment error. An alignment error is raised for a bad beat size, a size mix inside one unit, a misaligned unit start or a non-contiguous beat. Any error throws away the partly assembled unit.

Top module: `fpw_ctrl`

## Requirements
- R1: With width select 0 a unit is 32 bits and must start at an address with bits [1:0] equal to 0. With width select 1 a unit is 64 bits and must start with bits [2:0] equal to 0. A misaligned first beat, or a later beat whose address does not follow the previous beat, sets the alignment-error flag (status bit 3) and programs nothing.
- R2: Word beats (size code 2) complete a 32-bit unit in one write and a 64-bit unit in two. The beat at the lower address fills the lower bits of the unit.
- R3: Halfword beats (size code 1) complete a 32-bit unit in two writes and a 64-bit unit in four, filling the unit from its low bits upward.
- R4: A beat with size code 0 (byte) or 3 sets the alignment-error flag and discards the partial unit.
- R5: A beat whose size differs from the earlier beats of the same unit sets the alignment-error flag and discards the unit. The next unit then assembles from a clean start.
- R6: A unit whose target does not read as all ones sets the program-error flag (status bit 2) and is not programmed, even when its data is all zeros.
- R7: A unit that targets a page marked in the protect mask (page = address bits [13:10]) is dropped with no array access and no flag set.
- R8: Busy (status bit 0) is high from the cycle after a unit completes until the array finishes. Bus writes arriving while busy is high have no effect.
- R9: A finished program operation sets the end flag (status bit 1). irq_end is high while that flag and the end-interrupt enable (control bit 2) are both set.
- R10: irq_err is high while either error flag is set and the error-interrupt enable (control bit 3) is set.
- R11: Bus writes are ignored unless program enable (control bit 0) is set and the address bits [31:24] equal 0x08.
- R12: After reset the lock bit (control bit 7) is 1, and control writes are ignored while it is set. An unlock_i pulse clears it, and writing 1 to bit 7 sets it again.
- R13: The status flags are cleared by writing 1 to their bit positions. Writing 0 leaves them unchanged, and every flag resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unlock_i | input | 1 | One-cycle pulse that clears the lock bit |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register |
| bw_valid | input | 1 | Bus write strobe |
| bw_addr | input | 32 | Bus write byte address |
| bw_size | input | 2 | Beat size code: 0 byte, 1 halfword, 2 word, 3 invalid |
| bw_data | input | 32 | Bus write data, halfword in bits [15:0] |
| wp_mask | input | 16 | Write-protect bit for each page |
| fa_rd_addr | output | 32 | Array read address for the erase check |
| fa_rd_data | input | 64 | Array contents starting at fa_rd_addr |
| fa_prog | output | 1 | Program request, held until fa_done |
| fa_addr | output | 32 | Program target address |
| fa_wdata | output | 64 | Program data; for 32-bit units only bits [31:0] count |
| fa_wide | output | 1 | Program unit is 64 bits |
| fa_done | input | 1 | Array completion pulse |
| irq_end | output | 1 | End-of-operation interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
Some rules are checked on every cycle by the assertions. Program target and data stay fixed while a request is pending. A request only starts two cycles after a unit completed, against an erased and unprotected target. Disabled or busy periods never complete a unit. A size mix or byte beat always empties the assembly count. Lock freezes the control fields, and write-one-to-clear and event-set act on the end flag. Only the bench scenarios can show the assembled data and its lane order as stored in the array, that each beat count matches the unit width, and that protected or non-blank targets leave the array contents untouched. The same holds for a clean unit after a discarded one and for the interrupt gating.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

  typedef enum logic [1:0] {
    BW_BYTE = 2'd0,
    BW_HALF = 2'd1,
    BW_WORD = 2'd2,
    BW_RSVD = 2'd3
  } bw_size_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_CHECK = 2'd1,
    SQ_PROG  = 2'd2
  } sq_state_e;

  localparam int BEAT_W = 32;
  localparam int UNIT_W = 64;

  // control / status bit positions
  localparam int CT_PG   = 0;
  localparam int CT_WIDE = 1;
  localparam int CT_EIE  = 2;
  localparam int CT_XIE  = 3;
  localparam int CT_LOCK = 7;
  localparam int ST_BUSY = 0;
  localparam int ST_END  = 1;
  localparam int ST_PERR = 2;
  localparam int ST_AERR = 3;

  function automatic logic [3:0] beat_bytes(input logic [1:0] sz);
    return (sz == BW_HALF) ? 4'd2 : 4'd4;
  endfunction

  function automatic logic [2:0] beats_needed(input logic wide, input logic [1:0] sz);
    if (wide) return (sz == BW_HALF) ? 3'd4 : 3'd2;
    return (sz == BW_HALF) ? 3'd2 : 3'd1;
  endfunction

  function automatic logic unit_aligned(input logic [2:0] lsb, input logic wide);
    return wide ? (lsb == 3'd0) : (lsb[1:0] == 2'd0);
  endfunction

  function automatic logic unit_blank(input logic [UNIT_W-1:0] d, input logic wide);
    return wide ? (&d) : (&d[31:0]);
  endfunction

  function automatic logic [UNIT_W-1:0] place_beat(input logic [UNIT_W-1:0] acc,
                                                   input logic [BEAT_W-1:0] beat,
                                                   input logic [2:0] off,
                                                   input logic [1:0] sz);
    logic [UNIT_W-1:0] r;
    r = acc;
    if (sz == BW_HALF) r[{off, 3'b000} +: 16] = beat[15:0];
    else               r[{off[2], 5'b00000} +: 32] = beat;
    return r;
  endfunction

endpackage

// File: rtl/fpw_regs.sv
module fpw_regs
  import fpw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       unlock,
  input  logic       reg_we,
  input  logic       reg_sel,
  input  logic [7:0] reg_wdata,
  input  logic       busy,
  input  logic       end_evt,
  input  logic       perr_evt,
  input  logic       aerr_evt,
  output logic [7:0] reg_rdata,
  output logic       pg_en,
  output logic       wide,
  output logic       irq_end,
  output logic       irq_err
);

  logic lock_q, pg_q, wide_q, eie_q, xie_q;
  logic end_q, perr_q, aerr_q;
  logic ctl_wr, st_wr;
  wire  unused_wdata = &{1'b0, reg_wdata[6:4]};

  assign ctl_wr = reg_we && !reg_sel && !lock_q;
  assign st_wr  = reg_we && reg_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      pg_q   <= 1'b0;
      wide_q <= 1'b0;
      eie_q  <= 1'b0;
      xie_q  <= 1'b0;
    end else begin
      if (unlock)                              lock_q <= 1'b0;
      else if (ctl_wr && reg_wdata[CT_LOCK])   lock_q <= 1'b1;
      if (ctl_wr) begin
        pg_q   <= reg_wdata[CT_PG];
        wide_q <= reg_wdata[CT_WIDE];
        eie_q  <= reg_wdata[CT_EIE];
        xie_q  <= reg_wdata[CT_XIE];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      end_q  <= 1'b0;
      perr_q <= 1'b0;
      aerr_q <= 1'b0;
    end else begin
      end_q  <= end_evt  | (end_q  & ~(st_wr & reg_wdata[ST_END]));
      perr_q <= perr_evt | (perr_q & ~(st_wr & reg_wdata[ST_PERR]));
      aerr_q <= aerr_evt | (aerr_q & ~(st_wr & reg_wdata[ST_AERR]));
    end
  end

  assign reg_rdata = reg_sel ? {4'b0000, aerr_q, perr_q, end_q, busy}
                             : {lock_q, 3'b000, xie_q, eie_q, wide_q, pg_q};
  assign pg_en   = pg_q;
  assign wide    = wide_q;
  assign irq_end = end_q & eie_q;
  assign irq_err = (perr_q | aerr_q) & xie_q;

  a_r12_lock_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !unlock) |=> $stable({pg_q, wide_q, eie_q, xie_q}));
  a_r9_end_sets: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> end_q);
  a_r13_w1c_end: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && reg_wdata[ST_END] && !end_evt) |=> !end_q);

endmodule

// File: rtl/fpw_gather.sv
module fpw_gather
  import fpw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [AW-1:0]     bw_addr,
  input  logic [1:0]        bw_size,
  input  logic [BEAT_W-1:0] bw_data,
  input  logic              wide,
  output logic              unit_done,
  output logic              align_err,
  output logic [AW-1:0]     unit_addr,
  output logic [UNIT_W-1:0] unit_data
);

  logic [2:0]        cnt_q;
  logic [AW-1:0]     base_q;
  logic [1:0]        psz_q;
  logic [UNIT_W-1:0] acc_q;

  logic              first, bad, last;
  logic [AW-1:0]     exp_addr;
  logic [2:0]        off;
  logic [UNIT_W-1:0] merged;

  always_comb begin
    first    = (cnt_q == 3'd0);
    exp_addr = base_q + AW'(cnt_q) * AW'(beat_bytes(psz_q));
    bad      = !(bw_size == BW_HALF || bw_size == BW_WORD)
             || (!first && (bw_size != psz_q))
             || (first && !unit_aligned(bw_addr[2:0], wide))
             || (!first && (bw_addr != exp_addr));
    off      = first ? 3'd0 : 3'(bw_addr - base_q);
    merged   = place_beat(first ? '0 : acc_q, bw_data, off, bw_size);
    last     = ((cnt_q + 3'd1) == beats_needed(wide, bw_size));
  end

  assign align_err = accept && bad;
  assign unit_done = accept && !bad && last;
  assign unit_addr = first ? bw_addr : base_q;
  assign unit_data = merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= 3'd0;
      base_q <= '0;
      psz_q  <= BW_WORD;
      acc_q  <= '0;
    end else if (accept) begin
      if (bad || last) begin
        cnt_q <= 3'd0;
      end else begin
        cnt_q <= cnt_q + 3'd1;
        acc_q <= merged;
        psz_q <= bw_size;
        if (first) base_q <= bw_addr;
      end
    end
  end

  a_r5_mix_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cnt_q != 3'd0 && bw_size != psz_q) |=> (cnt_q == 3'd0));
  a_r4_byte_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && bw_size == BW_BYTE) |=> (cnt_q == 3'd0));

endmodule

// File: rtl/fpw_seq.sv
module fpw_seq
  import fpw_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NPAGES     = 16,
  parameter int PAGE_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_done,
  input  logic [AW-1:0]     unit_addr,
  input  logic [UNIT_W-1:0] unit_data,
  input  logic              wide,
  input  logic [NPAGES-1:0] wp_mask,
  output logic [AW-1:0]     fa_rd_addr,
  input  logic [UNIT_W-1:0] fa_rd_data,
  output logic              fa_prog,
  output logic [AW-1:0]     fa_addr,
  output logic [UNIT_W-1:0] fa_wdata,
  output logic              fa_wide,
  input  logic              fa_done,
  output logic              busy,
  output logic              end_evt,
  output logic              perr_evt
);

  localparam int PG_LSB = $clog2(PAGE_BYTES);
  localparam int PG_W   = $clog2(NPAGES);

  sq_state_e         st_q;
  logic [AW-1:0]     addr_q;
  logic [UNIT_W-1:0] data_q;
  logic              wide_q;
  logic              prot, blank;

  assign prot  = wp_mask[addr_q[PG_LSB +: PG_W]];
  assign blank = unit_blank(fa_rd_data, wide_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      addr_q <= '0;
      data_q <= '0;
      wide_q <= 1'b0;
    end else begin
      case (st_q)
        SQ_IDLE: if (unit_done) begin
          st_q   <= SQ_CHECK;
          addr_q <= unit_addr;
          data_q <= unit_data;
          wide_q <= wide;
        end
        SQ_CHECK: st_q <= (prot || !blank) ? SQ_IDLE : SQ_PROG;
        SQ_PROG:  if (fa_done) st_q <= SQ_IDLE;
        default:  st_q <= SQ_IDLE;
      endcase
    end
  end

  assign perr_evt   = (st_q == SQ_CHECK) && !prot && !blank;
  assign end_evt    = (st_q == SQ_PROG) && fa_done;
  assign fa_prog    = (st_q == SQ_PROG);
  assign fa_addr    = addr_q;
  assign fa_rd_addr = addr_q;
  assign fa_wdata   = data_q;
  assign fa_wide    = wide_q;
  assign busy       = (st_q != SQ_IDLE);

  a_r8_target_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fa_prog && !fa_done) |=> ($stable(fa_addr) && $stable(fa_wdata) && fa_prog));
  a_r2_prog_after_unit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fa_prog) |-> $past(unit_done, 2));
  a_r6_prog_only_blank: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fa_prog) |-> $past(blank));
  a_r7_prog_unprotected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fa_prog) |-> $past(!prot));

endmodule

// File: rtl/fpw_ctrl.sv
module fpw_ctrl
  import fpw_pkg::*;
#(
  parameter int         AW         = 32,
  parameter int         NPAGES     = 16,
  parameter int         PAGE_BYTES = 1024,
  parameter logic [7:0] FLASH_TAG  = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unlock_i,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              bw_valid,
  input  logic [AW-1:0]     bw_addr,
  input  logic [1:0]        bw_size,
  input  logic [BEAT_W-1:0] bw_data,
  input  logic [NPAGES-1:0] wp_mask,
  output logic [AW-1:0]     fa_rd_addr,
  input  logic [UNIT_W-1:0] fa_rd_data,
  output logic              fa_prog,
  output logic [AW-1:0]     fa_addr,
  output logic [UNIT_W-1:0] fa_wdata,
  output logic              fa_wide,
  input  logic              fa_done,
  output logic              irq_end,
  output logic              irq_err
);

  logic              pg_en, wide, busy, accept;
  logic              unit_done, align_err, end_evt, perr_evt;
  logic [AW-1:0]     unit_addr;
  logic [UNIT_W-1:0] unit_data;

  assign accept = bw_valid && pg_en && !busy && (bw_addr[AW-1 -: 8] == FLASH_TAG);

  fpw_regs u_regs (
    .clk(clk), .rst_n(rst_n), .unlock(unlock_i),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .busy(busy), .end_evt(end_evt), .perr_evt(perr_evt), .aerr_evt(align_err),
    .reg_rdata(reg_rdata), .pg_en(pg_en), .wide(wide),
    .irq_end(irq_end), .irq_err(irq_err)
  );

  fpw_gather #(.AW(AW)) u_gather (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .bw_addr(bw_addr), .bw_size(bw_size), .bw_data(bw_data), .wide(wide),
    .unit_done(unit_done), .align_err(align_err),
    .unit_addr(unit_addr), .unit_data(unit_data)
  );

  fpw_seq #(.AW(AW), .NPAGES(NPAGES), .PAGE_BYTES(PAGE_BYTES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .unit_done(unit_done), .unit_addr(unit_addr), .unit_data(unit_data), .wide(wide),
    .wp_mask(wp_mask), .fa_rd_addr(fa_rd_addr), .fa_rd_data(fa_rd_data),
    .fa_prog(fa_prog), .fa_addr(fa_addr), .fa_wdata(fa_wdata), .fa_wide(fa_wide),
    .fa_done(fa_done), .busy(busy), .end_evt(end_evt), .perr_evt(perr_evt)
  );

  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(unit_done || align_err));
  a_r11_disabled_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_valid && !pg_en) |-> !(unit_done || align_err));

endmodule

// File: tb/fpw_ctrl_tb.sv
`timescale 1ns/1ps
module fpw_ctrl_tb;

  typedef struct packed {
    logic        wide;
    logic [1:0]  sz;
    logic [2:0]  nwr;
    logic [31:0] addr;
    logic [63:0] data;
    logic [1:0]  code;   // 0 programmed, 1 align err, 2 program err, 3 dropped
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b0, 2'd2, 3'd1, 32'h0800_0000, 64'h0000_0000_1234_5678, 2'd0},
    '{1'b1, 2'd2, 3'd2, 32'h0800_0008, 64'hA5A5_0000_1111_2222, 2'd0},
    '{1'b0, 2'd1, 3'd2, 32'h0800_0014, 64'h0000_0000_BEEF_CAFE, 2'd0},
    '{1'b1, 2'd1, 3'd4, 32'h0800_0020, 64'h0123_4567_89AB_CDEF, 2'd0},
    '{1'b1, 2'd2, 3'd1, 32'h0800_0024, 64'h0000_0000_5555_5555, 2'd1},
    '{1'b0, 2'd2, 3'd1, 32'h0800_0000, 64'h0000_0000_0000_0000, 2'd2},
    '{1'b0, 2'd2, 3'd1, 32'h0800_0400, 64'h0000_0000_7777_7777, 2'd3},
    '{1'b0, 2'd1, 3'd1, 32'h0800_0002, 64'h0000_0000_0000_9999, 2'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        unlock_i, reg_we, reg_sel, bw_valid, fa_done;
  logic [7:0]  reg_wdata, reg_rdata;
  logic [31:0] bw_addr, bw_data, fa_rd_addr, fa_addr;
  logic [1:0]  bw_size;
  logic [15:0] wp_mask;
  logic [63:0] fa_rd_data, fa_wdata;
  logic        fa_prog, fa_wide, irq_end, irq_err;

  logic [63:0] mem [64];
  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  fpw_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .unlock_i(unlock_i),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .bw_valid(bw_valid), .bw_addr(bw_addr), .bw_size(bw_size), .bw_data(bw_data),
    .wp_mask(wp_mask), .fa_rd_addr(fa_rd_addr), .fa_rd_data(fa_rd_data),
    .fa_prog(fa_prog), .fa_addr(fa_addr), .fa_wdata(fa_wdata), .fa_wide(fa_wide),
    .fa_done(fa_done), .irq_end(irq_end), .irq_err(irq_err)
  );

  function automatic int midx(input logic [31:0] a);
    return int'({a[11:10], a[6:3]});
  endfunction

  // behavioural array: read port
  always_comb begin
    logic [63:0] d;
    d = mem[midx(fa_rd_addr)];
    fa_rd_data = fa_rd_addr[2] ? {32'hFFFF_FFFF, d[63:32]} : d;
  end

  // behavioural array: program responder
  initial begin
    int dly;
    dly = 0;
    fa_done = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = '1;
    forever begin
      @(negedge clk);
      if (fa_done) fa_done = 1'b0;
      else if (fa_prog) begin
        if (dly == 4) begin
          dly = 0;
          fa_done = 1'b1;
          if (fa_wide)         mem[midx(fa_addr)] = fa_wdata;
          else if (fa_addr[2]) mem[midx(fa_addr)][63:32] = fa_wdata[31:0];
          else                 mem[midx(fa_addr)][31:0]  = fa_wdata[31:0];
        end else dly++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic sel, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic sel, output logic [7:0] d);
    @(negedge clk); reg_sel = sel; #1 d = reg_rdata;
  endtask

  task automatic bus_wr(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk); bw_valid = 1'b1; bw_addr = a; bw_size = sz; bw_data = d;
    @(negedge clk); bw_valid = 1'b0;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 60; i++) begin
      reg_rd(1'b1, s);
      if (!s[0]) break;
    end
  endtask

  function automatic logic [63:0] exp_mem(input logic [63:0] old, input logic [63:0] d,
                                          input logic wide, input logic a2);
    if (wide) return d;
    return a2 ? {d[31:0], old[31:0]} : {old[63:32], d[31:0]};
  endfunction

  function automatic string tag_of(input int k);
    case (k)
      0, 1: return "R2";
      2, 3: return "R3";
      5:    return "R6";
      6:    return "R7";
      default: return "R1";
    endcase
  endfunction

  initial begin
    logic [7:0]  s;
    logic [63:0] old;
    rst_n = 1'b0; unlock_i = 1'b0; reg_we = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
    bw_valid = 1'b0; bw_addr = '0; bw_size = '0; bw_data = '0; wp_mask = 16'h0002;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    reg_rd(1'b1, s); chk("R13 reset status", 64'(s), 64'h00);
    reg_rd(1'b0, s); chk("R12 reset control", 64'(s), 64'h80);
    chk("R9 reset irq_end", 64'(irq_end), 64'd0);
    chk("R10 reset irq_err", 64'(irq_err), 64'd0);

    // R12: locked control write ignored, unlock, then write accepted
    reg_wr(1'b0, 8'h01);
    reg_rd(1'b0, s); chk("R12 locked write ignored", 64'(s), 64'h80);
    @(negedge clk); unlock_i = 1'b1; @(negedge clk); unlock_i = 1'b0;
    reg_wr(1'b0, 8'h01);
    reg_rd(1'b0, s); chk("R12 unlocked write", 64'(s), 64'h01);

    // table of program scenarios
    for (int k = 0; k < 8; k++) begin
      vec_t v;
      int   bits;
      logic [63:0] sh;
      v = VEC[k];
      bits = (v.sz == 2'd1) ? 16 : 32;
      reg_wr(1'b0, {6'b0, v.wide, 1'b1});
      reg_wr(1'b1, 8'h0E);
      old = mem[midx(v.addr)];
      for (int i = 0; i < int'(v.nwr); i++) begin
        sh = v.data >> (i * bits);
        bus_wr(v.addr + 32'(i * bits / 8), v.sz, sh[31:0]);
      end
      wait_idle();
      reg_rd(1'b1, s);
      case (v.code)
        2'd0: begin
          chk({tag_of(k), " status"}, 64'(s), 64'h02);
          chk({tag_of(k), " array"}, mem[midx(v.addr)], exp_mem(old, v.data, v.wide, v.addr[2]));
        end
        2'd1: begin
          chk({tag_of(k), " status"}, 64'(s), 64'h08);
          chk({tag_of(k), " array"}, mem[midx(v.addr)], old);
        end
        2'd2: begin
          chk({tag_of(k), " status"}, 64'(s), 64'h04);
          chk({tag_of(k), " array"}, mem[midx(v.addr)], old);
        end
        default: begin
          chk({tag_of(k), " status"}, 64'(s), 64'h00);
          chk({tag_of(k), " array"}, mem[midx(v.addr)], old);
        end
      endcase
    end
    reg_wr(1'b1, 8'h0E);

    // R11: program enable off, and out-of-window address
    reg_wr(1'b0, 8'h00);
    old = mem[midx(32'h0800_0040)];
    bus_wr(32'h0800_0040, 2'd2, 32'h0);
    repeat (10) @(negedge clk);
    reg_rd(1'b1, s); chk("R11 disabled status", 64'(s), 64'h00);
    chk("R11 disabled array", mem[midx(32'h0800_0040)], old);
    reg_wr(1'b0, 8'h01);
    bus_wr(32'h0900_0048, 2'd0, 32'h0);
    repeat (10) @(negedge clk);
    reg_rd(1'b1, s); chk("R11 outside window", 64'(s), 64'h00);

    // R4: byte beat
    bus_wr(32'h0800_0058, 2'd0, 32'h0);
    reg_rd(1'b1, s); chk("R4 byte beat", 64'(s), 64'h08);
    reg_wr(1'b1, 8'h08);

    // R5: size mix then clean unit
    bus_wr(32'h0800_0060, 2'd1, 32'h1111);
    bus_wr(32'h0800_0062, 2'd2, 32'h2222_3333);
    reg_rd(1'b1, s); chk("R5 size mix", 64'(s), 64'h08);
    reg_wr(1'b1, 8'h08);
    bus_wr(32'h0800_0060, 2'd1, 32'h1111);
    bus_wr(32'h0800_0062, 2'd1, 32'h2222);
    wait_idle();
    reg_rd(1'b1, s); chk("R5 clean unit status", 64'(s), 64'h02);
    chk("R5 clean unit array", mem[midx(32'h0800_0060)][31:0], 64'h2222_1111);
    reg_wr(1'b1, 8'h0E);

    // R8: busy and writes during busy
    old = mem[midx(32'h0800_0070)];
    bus_wr(32'h0800_0068, 2'd2, 32'h0000_DEAD);
    reg_rd(1'b1, s); chk("R8 busy high", 64'(s[0]), 64'd1);
    bus_wr(32'h0800_0070, 2'd2, 32'h0);
    wait_idle();
    reg_rd(1'b1, s); chk("R8 busy write ignored status", 64'(s), 64'h02);
    chk("R8 busy write ignored array", mem[midx(32'h0800_0070)], old);
    reg_wr(1'b1, 8'h0E);

    // R9 / R13 / R10: interrupts and W1C
    reg_wr(1'b0, 8'h0D);
    bus_wr(32'h0800_0078, 2'd2, 32'h0000_0001);
    wait_idle();
    @(negedge clk);
    chk("R9 irq_end raised", 64'(irq_end), 64'd1);
    chk("R10 irq_err idle", 64'(irq_err), 64'd0);
    reg_wr(1'b1, 8'h00);
    reg_rd(1'b1, s); chk("R13 write zero keeps", 64'(s), 64'h02);
    reg_wr(1'b1, 8'h02);
    reg_rd(1'b1, s); chk("R13 write one clears", 64'(s), 64'h00);
    chk("R9 irq_end dropped", 64'(irq_end), 64'd0);
    bus_wr(32'h0800_0030, 2'd0, 32'h0);
    @(negedge clk);
    chk("R10 irq_err raised", 64'(irq_err), 64'd1);
    reg_wr(1'b0, 8'h05);
    @(negedge clk);
    chk("R10 irq_err masked", 64'(irq_err), 64'd0);
    reg_wr(1'b1, 8'h08);

    // R12: set lock by write
    reg_wr(1'b0, 8'h80);
    reg_wr(1'b0, 8'h01);
    reg_rd(1'b0, s); chk("R12 relocked", 64'(s), 64'h80);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule